// File: doc/BRIEF.md
# Linked Reservation Monitor for a Shared Word Memory

This block sits in front of a small word-addressed memory that several requesting cores share (two by default). Each cycle it accepts one request from one core and performs one of four operations on the memory: a plain read, a plain write, a reserving read, or a conditional write. A reserving read returns the addressed word and records, for that core, a reservation on that address. A conditional write is committed only if the core's reservation is still live and names the same address. It then returns 1; otherwise memory is left alone and it returns 0. Any committed write to a reserved address kills that reservation, whichever core wrote it. A core can therefore build an atomic swap or increment by repeating reserving read and conditional write until the result is 1.

Requests from different cores that arrive together are serialised by a rotating-priority arbiter. A core that is not served sees its ready low and keeps its request up. The response comes back one cycle after the grant.

Top module: `llsc_monitor`

## Requirements
- R1: While reset is high, no core is given ready. After reset every memory word reads 0, no core holds a reservation, and rsp_valid is 0.
- R2: At most one core is granted per cycle, and a core is only granted when it has req_valid high.
- R3: Priority rotates. Core 0 holds it first after reset, and after a grant priority passes to the next core in index order, wrapping around. With both cores requesting on consecutive cycles, the grant alternates.
- R4: A granted request produces rsp_valid high for the granted core only, exactly one cycle after the grant. No other cycle and no other core sees it.
- R5: Operation codes are 2'b00 plain read, 2'b01 plain write, 2'b10 reserving read and 2'b11 conditional write. A plain read returns the word. A plain write stores req_wdata and returns 0.
- R6: A reserving read returns the word and sets the issuing core's reservation to that address.
- R7: A conditional write whose core holds a live reservation on the same address stores the data and returns 1.
- R8: A conditional write from a core with no live reservation, or with a reservation on another address, leaves memory unchanged and returns 0.
- R9: A conditional write clears its own core's reservation whether it succeeds or fails, so a second conditional write to the same address fails.
- R10: A committed write to an address (plain write or successful conditional write, from any core, the owner included) clears every reservation on that address. Writes to other addresses leave reservations intact.
- R11: A new reserving read replaces the core's previous reservation, so a conditional write to the earlier address fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NUM_CORES | Per-core request present |
| req_op | input | 2*NUM_CORES | Per-core operation code, 2 bits per core |
| req_addr | input | ADDR_W*NUM_CORES | Per-core word address |
| req_wdata | input | DATA_W*NUM_CORES | Per-core write data |
| req_ready | output | NUM_CORES | Grant; the request is taken in this cycle |
| rsp_valid | output | NUM_CORES | Per-core response strobe, one cycle after grant |
| rsp_data | output | DATA_W*NUM_CORES | Per-core result: read word, or 1/0 for a conditional write |

## Verification
The case that matters most is a reservation being cancelled while a competing write is being arbitrated. The bench provokes it by having both cores issue a reserving read of one address in the same cycle, then both issue a conditional write to it in the same cycle. The first core served must get 1 and its write must kill the other core's reservation, so the second must get 0. A long random run over only four addresses keeps producing such collisions, and every cycle it is compared against a behavioural model of memory, reservations and priority.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_LINK  = 2'b10,
        OP_COND  = 2'b11
    } op_e;

    // True when the granted operation changes memory.
    function automatic logic commits_write(input op_e op, input logic cond_ok);
        return (op == OP_WRITE) || ((op == OP_COND) && cond_ok);
    endfunction

    // Next priority holder after a grant to index idx among n requesters.
    function automatic int next_holder(input int idx, input int n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/llsc_arbiter.sv
module llsc_arbiter
    import llsc_pkg::*;
#(
    parameter int NUM_CORES = 2,
    parameter int IDX_W     = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_CORES-1:0] req,
    output logic [NUM_CORES-1:0] gnt,
    output logic [IDX_W-1:0]     sel,
    output logic                 any
);

    logic [IDX_W-1:0] prio_q;

    always_comb begin
        gnt = '0;
        sel = '0;
        any = 1'b0;
        for (int k = 0; k < NUM_CORES; k++) begin
            int idx;
            idx = (int'(prio_q) + k) % NUM_CORES;
            if (!any && req[idx]) begin
                gnt[idx] = 1'b1;
                sel      = IDX_W'(idx);
                any      = 1'b1;
            end
        end
        if (rst) begin
            gnt = '0;
            any = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prio_q <= '0;
        end else if (any) begin
            prio_q <= IDX_W'(next_holder(int'(sel), NUM_CORES));
        end
    end

    assert_one_grant_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));

    assert_grant_only_requested_R2: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~req) == '0);

    assert_rotate_on_contention_R3: assert property (@(posedge clk) disable iff (rst)
        ((&req) && ($past(gnt) != '0)) |-> ((gnt & $past(gnt)) == '0));

endmodule

// File: rtl/llsc_resv.sv
module llsc_resv #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ll_set,
    input  logic              sc_take,
    input  logic              wr_commit,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              hit
);

    logic              valid_q;
    logic [ADDR_W-1:0] addr_q;

    assign hit = valid_q && (addr_q == probe_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            addr_q  <= '0;
        end else if (ll_set) begin
            valid_q <= 1'b1;
            addr_q  <= probe_addr;
        end else if (sc_take) begin
            valid_q <= 1'b0;
        end else if (wr_commit && hit) begin
            valid_q <= 1'b0;
        end
    end

    assert_link_sets_R6: assert property (@(posedge clk) disable iff (rst)
        ll_set |=> (valid_q && (addr_q == $past(probe_addr))));

    assert_cond_clears_R9: assert property (@(posedge clk) disable iff (rst)
        sc_take |=> !valid_q);

    assert_write_cancels_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_commit && valid_q && (addr_q == probe_addr) && !ll_set) |=> !valid_q);

endmodule

// File: rtl/llsc_store.sv
module llsc_store #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];

    assign rdata = words[addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                words[i] <= '0;
            end
        end else if (we) begin
            words[addr] <= wdata;
        end
    end

    assert_write_lands_R5: assert property (@(posedge clk) disable iff (rst)
        we |=> (words[$past(addr)] == $past(wdata)));

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int NUM_CORES = 2,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_CORES-1:0]          req_valid,
    input  logic [2*NUM_CORES-1:0]        req_op,
    input  logic [ADDR_W*NUM_CORES-1:0]   req_addr,
    input  logic [DATA_W*NUM_CORES-1:0]   req_wdata,
    output logic [NUM_CORES-1:0]          req_ready,
    output logic [NUM_CORES-1:0]          rsp_valid,
    output logic [DATA_W*NUM_CORES-1:0]   rsp_data
);

    localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

    logic [NUM_CORES-1:0] gnt;
    logic [IDX_W-1:0]     sel;
    logic                 any_gnt;

    op_e                  g_op;
    logic [ADDR_W-1:0]    g_addr;
    logic [DATA_W-1:0]    g_wdata;
    logic [NUM_CORES-1:0] hit;
    logic                 cond_ok;
    logic                 wr_en;
    logic [DATA_W-1:0]    mem_rdata;
    logic [DATA_W-1:0]    result;

    logic [NUM_CORES-1:0] rsp_valid_q;
    logic [DATA_W-1:0]    rsp_q;

    llsc_arbiter #(
        .NUM_CORES(NUM_CORES),
        .IDX_W    (IDX_W)
    ) arb_i (
        .clk(clk),
        .rst(rst),
        .req(req_valid),
        .gnt(gnt),
        .sel(sel),
        .any(any_gnt)
    );

    assign req_ready = gnt;

    always_comb begin
        g_op    = op_e'(req_op[sel*2 +: 2]);
        g_addr  = req_addr[sel*ADDR_W +: ADDR_W];
        g_wdata = req_wdata[sel*DATA_W +: DATA_W];
    end

    assign cond_ok = hit[sel];
    assign wr_en   = any_gnt && commits_write(g_op, cond_ok);

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_resv
        llsc_resv #(
            .ADDR_W(ADDR_W)
        ) resv_i (
            .clk       (clk),
            .rst       (rst),
            .ll_set    (gnt[c] && (g_op == OP_LINK)),
            .sc_take   (gnt[c] && (g_op == OP_COND)),
            .wr_commit (wr_en),
            .probe_addr(g_addr),
            .hit       (hit[c])
        );
        assign rsp_data[c*DATA_W +: DATA_W] = rsp_q;
    end

    llsc_store #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) store_i (
        .clk  (clk),
        .rst  (rst),
        .we   (wr_en),
        .addr (g_addr),
        .wdata(g_wdata),
        .rdata(mem_rdata)
    );

    always_comb begin
        unique case (g_op)
            OP_READ, OP_LINK: result = mem_rdata;
            OP_WRITE:         result = '0;
            OP_COND:          result = {{(DATA_W-1){1'b0}}, cond_ok};
            default:          result = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_q <= '0;
            rsp_q       <= '0;
        end else begin
            rsp_valid_q <= gnt;
            if (any_gnt) begin
                rsp_q <= result;
            end
        end
    end

    assign rsp_valid = rsp_valid_q;

    assert_rsp_follows_grant_R4: assert property (@(posedge clk) disable iff (rst)
        rsp_valid == $past(req_ready));

endmodule

// File: tb/llsc_monitor_tb.sv
module llsc_monitor_tb_top;

    localparam int NC = 2;
    localparam int AW = 4;
    localparam int DW = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NC-1:0]   req_valid = '0;
    logic [2*NC-1:0] req_op = '0;
    logic [AW*NC-1:0] req_addr = '0;
    logic [DW*NC-1:0] req_wdata = '0;
    logic [NC-1:0]   req_ready;
    logic [NC-1:0]   rsp_valid;
    logic [DW*NC-1:0] rsp_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    logic [DW-1:0] ref_mem [int];
    bit            ref_rv [NC];
    int            ref_ra [NC];
    int            ref_prio = 0;
    logic [DW-1:0] last_rsp = '0;

    always #4 clk = ~clk;

    llsc_monitor #(.NUM_CORES(NC), .ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] mem_rd(input int a);
        return ref_mem.exists(a) ? ref_mem[a] : '0;
    endfunction

    task automatic step(input logic v0, input logic [1:0] o0, input int a0, input logic [DW-1:0] d0,
                        input logic v1, input logic [1:0] o1, input int a1, input logic [DW-1:0] d1,
                        input string tag);
        int g;
        int a;
        logic [1:0] o;
        logic [DW-1:0] d;
        logic [DW-1:0] exp_d;
        logic [NC-1:0] exp_rdy;
        bit ok;
        @(negedge clk);
        req_valid = {v1, v0};
        req_op    = {o1, o0};
        req_addr  = {AW'(a1), AW'(a0)};
        req_wdata = {d1, d0};
        #1;
        g = -1;
        if (req_valid[ref_prio]) g = ref_prio;
        else if (req_valid[1 - ref_prio]) g = 1 - ref_prio;
        exp_rdy = '0;
        if (g >= 0) exp_rdy[g] = 1'b1;
        chk((v0 && v1) ? "R3 ready" : "R2 ready", DW'(req_ready), DW'(exp_rdy));
        exp_d = '0;
        if (g >= 0) begin
            o = (g == 0) ? o0 : o1;
            a = (g == 0) ? a0 : a1;
            d = (g == 0) ? d0 : d1;
            case (o)
                2'b00, 2'b10: exp_d = mem_rd(a);
                2'b01:        exp_d = '0;
                default: begin
                    ok = ref_rv[g] && (ref_ra[g] == a);
                    exp_d = DW'(ok);
                end
            endcase
            if (o == 2'b10) begin
                ref_rv[g] = 1; ref_ra[g] = a;
            end else if (o == 2'b11) begin
                ref_rv[g] = 0;
            end
            if (o == 2'b01 || (o == 2'b11 && exp_d[0])) begin
                ref_mem[a] = d;
                for (int c = 0; c < NC; c++)
                    if (ref_rv[c] && ref_ra[c] == a) ref_rv[c] = 0;
            end
            ref_prio = 1 - g;
        end
        @(posedge clk);
        #1;
        chk("R4 rsp_valid", DW'(rsp_valid), DW'(exp_rdy));
        if (g >= 0) begin
            chk(tag, rsp_data[g*DW +: DW], exp_d);
            last_rsp = rsp_data[g*DW +: DW];
        end
    endtask

    task automatic op0(input logic [1:0] o, input int a, input logic [DW-1:0] d, input string tag);
        step(1, o, a, d, 0, 2'b00, 0, '0, tag);
    endtask

    task automatic op1(input logic [1:0] o, input int a, input logic [DW-1:0] d, input string tag);
        step(0, 2'b00, 0, '0, 1, o, a, d, tag);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NC; c++) begin ref_rv[c] = 0; ref_ra[c] = 0; end
        // R1: requests during reset are not granted
        @(negedge clk);
        req_valid = 2'b11;
        #1;
        chk("R1 ready during reset", DW'(req_ready), '0);
        @(negedge clk);
        req_valid = '0;
        rst = 1'b0;
        #1;
        chk("R1 rsp_valid after reset", DW'(rsp_valid), '0);

        op0(2'b00, 3, '0, "R1 word reads zero");
        chk("R1 explicit", last_rsp, 32'h0);

        op0(2'b01, 2, 32'hAA, "R5 write result");
        chk("R5 write returns 0", last_rsp, 32'h0);
        op1(2'b00, 2, '0, "R5 read back");
        chk("R5 explicit", last_rsp, 32'hAA);

        op0(2'b10, 5, '0, "R6 link read");
        chk("R6 explicit", last_rsp, 32'h0);
        op0(2'b11, 5, 32'h55, "R7 cond ok");
        chk("R7 explicit", last_rsp, 32'h1);
        op1(2'b00, 5, '0, "R7 stored");
        chk("R7 stored explicit", last_rsp, 32'h55);

        op0(2'b11, 5, 32'h66, "R9 second cond");
        chk("R9 explicit", last_rsp, 32'h0);
        op1(2'b00, 5, '0, "R9 unchanged");
        chk("R9 unchanged explicit", last_rsp, 32'h55);

        op1(2'b11, 1, 32'h77, "R8 no reservation");
        chk("R8 explicit", last_rsp, 32'h0);
        op1(2'b00, 1, '0, "R8 unchanged");
        chk("R8 unchanged explicit", last_rsp, 32'h0);

        op0(2'b10, 6, '0, "R10 link");
        op1(2'b01, 6, 32'h11, "R10 other write");
        op0(2'b11, 6, 32'h22, "R10 cancelled");
        chk("R10 cancel explicit", last_rsp, 32'h0);
        op0(2'b00, 6, '0, "R10 value");
        chk("R10 value explicit", last_rsp, 32'h11);

        op0(2'b10, 7, '0, "R10 link");
        op1(2'b01, 8, 32'h12, "R10 other addr");
        op0(2'b11, 7, 32'h33, "R10 kept");
        chk("R10 kept explicit", last_rsp, 32'h1);

        op0(2'b10, 9, '0, "R10 link");
        op0(2'b01, 9, 32'h44, "R10 own write");
        op0(2'b11, 9, 32'h45, "R10 own cancel");
        chk("R10 own cancel explicit", last_rsp, 32'h0);

        op0(2'b10, 3, '0, "R11 link a");
        op0(2'b10, 4, '0, "R11 link b");
        op0(2'b11, 3, 32'h99, "R11 stale");
        chk("R11 explicit", last_rsp, 32'h0);
        op0(2'b00, 3, '0, "R11 unchanged");
        chk("R11 unchanged explicit", last_rsp, 32'h0);

        // contention: both link, both cond
        step(1, 2'b10, 12, '0, 1, 2'b10, 12, '0, "R3 link race");
        step(1, 2'b10, 12, '0, 1, 2'b10, 12, '0, "R3 link race");
        step(1, 2'b11, 12, 32'hC0, 1, 2'b11, 12, 32'hC1, "R7 first cond");
        chk("R7 race winner", last_rsp, 32'h1);
        step(1, 2'b11, 12, 32'hC0, 1, 2'b11, 12, 32'hC1, "R10 second cond");
        chk("R10 race loser", last_rsp, 32'h0);

        // random mix over a few addresses, model compared every cycle
        for (int i = 0; i < 600; i++) begin
            step(1'($urandom), 2'($urandom), int'($urandom % 4), $urandom,
                 1'($urandom), 2'($urandom), int'($urandom % 4), $urandom,
                 "R5 R6 R7 R8 random");
        end

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule